// File: doc/BRIEF.md
# Packed Operand Extractor for a 192-bit Memory Line

This block works on one 192-bit memory line. It reads an operand of an irregular width out of a fixed slot in the line and returns it right-justified. The line is built from sixteen 12-bit units. Because three or five items do not divide a power-of-two line evenly, the slots are not a plain lane multiplexer. Each operand kind has its own placement rule. Items of 60, 64 and 48 bits are packed from the left of the line. Items of 36 bits are packed from the right. Bytes and 9-bit characters sit inside those larger units.

On the same request the block can also write a new operand into the selected slot. It returns the merged line, and it still reports the field's old contents on the data output. Every response is registered and appears one clock after the request. An index that the chosen kind does not support flags an error. In that case the response carries zero data and the line unchanged.

In this document, "left" means bit 191 of the line. The 12-bit unit u, counted from the left, covers bits 191-12u down to 180-12u.

Top module: `packed_operand_extract`

## Requirements
- R1: While `rst` is high at a clock edge, `rsp_valid`, `rsp_err`, `rsp_data` and `rsp_line` are all cleared to zero.
- R2: `rsp_valid` equals `req_valid` one clock earlier. Every response field refers to the request of the previous cycle.
- R3: Kind 0 selects 60-bit slot s (s = 0..2), which covers units 5s to 5s+4 from the left. Unit 15 is never part of a slot.
- R4: Kind 1 selects 64-bit slot s (s = 0..2), which is the s-th third of the line counted from the left (bits 191-64s down to 128-64s).
- R5: Kind 2 selects a 48-bit item in the leftmost 48 bits of 60-bit slot s (s = 0..2).
- R6: Kind 3 selects 36-bit slot s (s = 0..4), which covers the three units that end at unit 15-3s. Slot 0 is the rightmost 36 bits of the line.
- R7: Kind 4 addresses the four 36-bit items in the right 144 bits of the line as 48-bit positions k = 0..3, taken left to right. Kind 5 addresses the two 36-bit items in the right 72 bits as 96-bit positions k = 0..1, taken left to right.
- R8: Kind 6 selects byte i (i = 0..23). Its 64-bit unit is i/8, as in R4. Within that unit the byte number is i mod 8, counted from the left.
- R9: Kind 7 selects 9-bit character i (i = 0..19). Its 36-bit slot is i/4, as in R6. Within that slot the character number is i mod 4, counted from the left.
- R10: With `req_write` high and a supported index, `rsp_line` is `line_in` with only the selected field replaced by the low bits of `wr_data`. `rsp_data` still returns the field's old contents.
- R11: With `req_write` low, `rsp_line` equals `line_in`.
- R12: An index beyond the range for the kind sets `rsp_err`, forces `rsp_data` to zero and returns `line_in` unchanged, even on a write.
- R13: The bits of `wr_data` above the operand width have no effect on `rsp_line`. The bits of `rsp_data` above the operand width are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Merge `wr_data` into the selected field |
| req_kind | input | 3 | Operand kind code, 0..7 |
| req_index | input | 5 | Slot, byte or character index |
| line_in | input | 192 | Memory line |
| wr_data | input | 64 | Operand to insert, right-justified |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Unsupported index |
| rsp_data | output | 64 | Extracted operand, right-justified |
| rsp_line | output | 192 | Line after an optional merge |

## Verification
A single request can read the old field and merge a new value into the same field. The response then carries both the old field and the updated line in the same cycle.

The bench provokes this case with random and directed write requests across every kind. It checks two things from separate reference models:
- `rsp_data` matches the field taken from the unmodified `line_in`.
- `rsp_line` matches the bit-by-bit merged line.

Writes that carry garbage above the operand width, and writes with out-of-range indices, check that neither path spills outside the selected field.

// File: rtl/pox_pkg.sv
package pox_pkg;
  localparam int LINE_W = 192;
  localparam int DATA_W = 64;
  localparam int UNIT_W = 12;
  localparam int IDX_W  = 5;
  localparam int KIND_W = 3;
  localparam int POS_W  = $clog2(LINE_W);
  localparam int WID_W  = $clog2(DATA_W + 1);
  localparam int UNITS  = LINE_W / UNIT_W;

  typedef enum logic [KIND_W-1:0] {
    K_W60     = 3'd0,
    K_W64     = 3'd1,
    K_W48IN60 = 3'd2,
    K_W36     = 3'd3,
    K_W36AS48 = 3'd4,
    K_W36AS96 = 3'd5,
    K_BYTE    = 3'd6,
    K_CHAR9   = 3'd7
  } op_kind_e;

  typedef struct packed {
    logic [POS_W-1:0] lsb;
    logic [WID_W-1:0] width;
    logic             err;
  } field_sel_t;
endpackage

// File: rtl/pox_slot_decode.sv
module pox_slot_decode
  import pox_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic [IDX_W-1:0]  index,
  output field_sel_t        sel
);
  localparam int W60 = 5 * UNIT_W;
  localparam int W36 = 3 * UNIT_W;

  always_comb begin
    int  s;
    int  lo;
    int  w;
    logic ok;
    s  = int'(index);
    lo = 0;
    w  = 0;
    ok = 1'b0;
    unique case (op_kind_e'(kind))
      K_W60: begin
        ok = (s < 3);
        lo = LINE_W - W60 * (s + 1);
        w  = W60;
      end
      K_W64: begin
        ok = (s < 3);
        lo = LINE_W - DATA_W * (s + 1);
        w  = DATA_W;
      end
      K_W48IN60: begin
        ok = (s < 3);
        lo = LINE_W - W60 * s - 4 * UNIT_W;
        w  = 4 * UNIT_W;
      end
      K_W36: begin
        ok = (s < 5);
        lo = W36 * s;
        w  = W36;
      end
      K_W36AS48: begin
        ok = (s < 4);
        lo = W36 * (3 - s);
        w  = W36;
      end
      K_W36AS96: begin
        ok = (s < 2);
        lo = W36 * (1 - s);
        w  = W36;
      end
      K_BYTE: begin
        ok = (s < 24);
        lo = LINE_W - DATA_W * (s / 8) - 8 * (s % 8) - 8;
        w  = 8;
      end
      K_CHAR9: begin
        ok = (s < 20);
        lo = W36 * (s / 4) + 27 - 9 * (s % 4);
        w  = 9;
      end
      default: ok = 1'b0;
    endcase
    if (!ok) begin
      lo = 0;
      w  = 0;
    end
    sel.lsb   = POS_W'(lo);
    sel.width = WID_W'(w);
    sel.err   = !ok;
  end
endmodule

// File: rtl/pox_field_extract.sv
module pox_field_extract
  import pox_pkg::*;
(
  input  logic [LINE_W-1:0] line,
  input  field_sel_t        sel,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] data
);
  logic [LINE_W-1:0] shifted;

  always_comb begin
    if (sel.width == '0)
      mask = '0;
    else
      mask = {DATA_W{1'b1}} >> (WID_W'(DATA_W) - sel.width);
    shifted = line >> sel.lsb;
    data    = shifted[DATA_W-1:0] & mask;
  end
endmodule

// File: rtl/pox_field_merge.sv
module pox_field_merge
  import pox_pkg::*;
(
  input  logic [LINE_W-1:0] line,
  input  field_sel_t        sel,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] wdata,
  input  logic              enable,
  output logic [LINE_W-1:0] merged
);
  localparam int PAD = LINE_W - DATA_W;
  logic [LINE_W-1:0] hole;
  logic [LINE_W-1:0] ins;

  always_comb begin
    hole = {{PAD{1'b0}}, mask} << sel.lsb;
    ins  = {{PAD{1'b0}}, wdata & mask} << sel.lsb;
    if (enable && !sel.err)
      merged = (line & ~hole) | ins;
    else
      merged = line;
  end
endmodule

// File: rtl/packed_operand_extract.sv
module packed_operand_extract
  import pox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_kind,
  input  logic [4:0]        req_index,
  input  logic [191:0]      line_in,
  input  logic [63:0]       wr_data,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_data,
  output logic [191:0]      rsp_line
);
  field_sel_t        sel;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] rd_field;
  logic [LINE_W-1:0] new_line;

  pox_slot_decode u_dec (
    .kind  (req_kind),
    .index (req_index),
    .sel   (sel)
  );

  pox_field_extract u_ext (
    .line (line_in),
    .sel  (sel),
    .mask (mask),
    .data (rd_field)
  );

  pox_field_merge u_mrg (
    .line   (line_in),
    .sel    (sel),
    .mask   (mask),
    .wdata  (wr_data),
    .enable (req_write),
    .merged (new_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      rsp_line  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_err  <= sel.err;
        rsp_data <= rd_field;
        rsp_line <= new_line;
      end
    end
  end
endmodule

// File: rtl/pox_chk.sv
module pox_chk (
  input logic         clk,
  input logic         rst,
  input logic         req_valid,
  input logic         req_write,
  input logic [2:0]   req_kind,
  input logic [4:0]   req_index,
  input logic [191:0] line_in,
  input logic         rsp_valid,
  input logic         rsp_err,
  input logic [63:0]  rsp_data,
  input logic [191:0] rsp_line
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> rsp_valid == $past(req_valid));

  // R12
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> rsp_data == 64'd0);

  // R12
  err_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && rsp_valid && rsp_err) |-> rsp_line == $past(line_in));

  // R11
  read_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && rsp_valid && !$past(req_write)) |-> rsp_line == $past(line_in));

  // R8
  byte_width_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && rsp_valid && $past(req_kind) == 3'd6) |-> rsp_data[63:8] == 56'd0);

  // R10
  w64_merge_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && rsp_valid && $past(req_write) && $past(req_kind) == 3'd1
     && $past(req_index) == 5'd0) |-> rsp_line[127:0] == $past(line_in[127:0]));
endmodule

bind packed_operand_extract pox_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_kind  (req_kind),
  .req_index (req_index),
  .line_in   (line_in),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_data  (rsp_data),
  .rsp_line  (rsp_line)
);

// File: tb/sim_packed_operand_extract.sv
`timescale 1ns/1ps
module sim_packed_operand_extract;
  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid, req_write;
  logic [2:0]   req_kind;
  logic [4:0]   req_index;
  logic [191:0] line_in;
  logic [63:0]  wr_data;
  logic         rsp_valid, rsp_err;
  logic [63:0]  rsp_data;
  logic [191:0] rsp_line;

  int n_vec  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  packed_operand_extract u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_kind(req_kind), .req_index(req_index), .line_in(line_in),
    .wr_data(wr_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_data(rsp_data), .rsp_line(rsp_line)
  );

  // left = offset of the field's first bit from bit 191
  function automatic void ref_place(input int kind, input int idx,
                                    output int left, output int w, output bit ok);
    left = 0; w = 0; ok = 0;
    case (kind)
      0: begin ok = idx < 3;  left = 60 * idx;          w = 60; end
      1: begin ok = idx < 3;  left = 64 * idx;          w = 64; end
      2: begin ok = idx < 3;  left = 60 * idx;          w = 48; end
      3: begin ok = idx < 5;  left = 12 * (13 - 3*idx); w = 36; end
      4: begin ok = idx < 4;  left = 48 + 36 * idx;     w = 36; end
      5: begin ok = idx < 2;  left = 120 + 36 * idx;    w = 36; end
      6: begin ok = idx < 24; left = 8 * idx;           w = 8;  end
      default: begin
        ok = idx < 20; left = 12 * (13 - 3*(idx/4)) + 9 * (idx % 4); w = 9;
      end
    endcase
  endfunction

  function automatic string kind_tag(input int kind);
    case (kind)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4, 5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [191:0] rnd_line();
    logic [191:0] v;
    for (int k = 0; k < 6; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check_bit(input bit cond, input string tag, input string what,
                           input logic [191:0] act, input logic [191:0] exp);
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input bit wr, input int kind, input int idx,
                       input logic [191:0] ln, input logic [63:0] wd);
    int left, w;
    bit ok;
    logic [63:0]  exp_d;
    logic [191:0] exp_l;
    string tag;
    ref_place(kind, idx, left, w, ok);
    exp_d = '0;
    exp_l = ln;
    if (ok) begin
      for (int j = 0; j < w; j++) begin
        exp_d[j] = ln[192 - left - w + j];
        if (wr) exp_l[192 - left - w + j] = wd[j];
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_kind = 3'(kind);
    req_index = 5'(idx); line_in = ln; wr_data = wd;
    @(negedge clk);
    req_valid = 1'b0;
    n_vec++;
    tag = !ok ? "R12" : (wr ? "R10" : kind_tag(kind));
    check_bit(rsp_valid == 1'b1, "R2", "valid", 192'(rsp_valid), 192'd1);
    check_bit(rsp_err == !ok, "R12", "err", 192'(rsp_err), 192'(!ok));
    check_bit(rsp_data == exp_d, tag, "data", 192'(rsp_data), 192'(exp_d));
    check_bit(rsp_line == exp_l, wr ? (ok ? "R10" : "R12") : "R11", "line",
              rsp_line, exp_l);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [191:0] pat;
    void'($urandom(32'h5EED_0192));
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_kind = '0;
    req_index = '0; line_in = '1; wr_data = '1;
    repeat (3) @(negedge clk);
    n_vec++;
    // R1 reset state
    check_bit(rsp_valid == 0 && rsp_err == 0, "R1", "flags",
              192'({rsp_valid, rsp_err}), 192'd0);
    check_bit(rsp_data == 0 && rsp_line == 0, "R1", "data/line",
              rsp_line | 192'(rsp_data), 192'd0);
    rst = 1'b0;
    @(negedge clk);
    // R2 idle cycle keeps valid low
    n_vec++;
    check_bit(rsp_valid == 0, "R2", "idle valid", 192'(rsp_valid), 192'd0);

    // directed: every kind, every index up to 31, unit-numbered line
    for (int u = 0; u < 16; u++) pat[191 - 12*u -: 12] = 12'(12'hA00 + u);
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < 32; i++) apply(1'b0, k, i, pat, 64'd0);

    // directed writes: read and merge in one request, garbage above width (R13)
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < 6; i++) apply(1'b1, k, i, rnd_line(), 64'hFFFF_FFFF_FFFF_FFFF);
    apply(1'b1, 3, 7, '0, '1);     // R12 write with bad index
    apply(1'b1, 6, 24, '1, '0);    // R12 first byte index past range
    apply(1'b1, 7, 19, '0, '1);    // R9 last character

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int k, i;
      logic [63:0] wd;
      k  = $urandom_range(7);
      i  = ($urandom_range(9) == 0) ? $urandom_range(31) :
           $urandom_range((k == 6) ? 23 : (k == 7) ? 19 : (k == 3) ? 4 : 3);
      wd = {$urandom, $urandom};
      apply(($urandom_range(1) == 1), k, i, rnd_line(), wd);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule